// File: doc/BRIEF.md
# I2S Serial Audio Receiver

This block turns a three-wire I2S stream into parallel stereo samples. It runs entirely on the serial bit clock. Each rising edge samples the word-select line and the data line. A change of word-select marks a word boundary. The word that follows is shifted in MSB first and placed left-justified in a 24-bit sample.

The word length comes from a static configuration input. The block also times every completed word-select half-period. When a half-period is exactly 16 bit clocks long, the next word is forced to 16 bits and a status flag is raised. Once a left word and the right word after it are both complete, the pair is presented together, with a one-cycle valid strobe.

Top module: `i2s_rx`

## Requirements
- R1: The MSB of a word is sampled on the second rising bit-clock edge after a word-select change. Each later edge supplies the next lower bit. The last bit of a 16-clock half is taken on the edge that sees the following word-select change.
- R2: A word received while word-select is low (value 0) appears on `left_o`. A word received while word-select is high (value 1) appears on `right_o`. Bit 23 of each output is the MSB.
- R3: `len_cfg_i` gives the word length in bits, as an unsigned value. Values below 16 act as 16 and values above 24 act as 24.
- R4: When the active word length is below 24, the unused low-order bits of the 24-bit output are zero.
- R5: Data bits that arrive after the active word length has been reached are ignored until the next word-select change.
- R6: A completed half-period of exactly 16 bit clocks forces the next word to 16 bits, whatever `len_cfg_i` says, and sets `packed_o`. A completed half-period of any other length clears `packed_o` and restores the configured length for the next word.
- R7: Any word-select duty cycle is accepted. Each word ends at the word-select change that follows it, and the left and right halves may differ in length.
- R8: `valid_o` is high for exactly one cycle. That cycle follows the edge at which a right word completes, provided the left word just before it is complete. `left_o` and `right_o` update together in that cycle and then hold their values.
- R9: A synchronous reset clears the outputs, the valid strobe, the packed flag and all counters.
- R10: After reset, the word in progress is discarded. No valid strobe occurs until a full left word and a full right word have been received after the first word-select change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| ws_i | input | 1 | Word select: 0 selects the left channel, 1 the right |
| sd_i | input | 1 | Serial data, MSB first |
| len_cfg_i | input | 5 | Configured word length in bits (16 to 24) |
| left_o | output | 24 | Left sample, left-justified |
| right_o | output | 24 | Right sample, left-justified |
| valid_o | output | 1 | One-cycle strobe marking a new sample pair |
| packed_o | output | 1 | High while 16-bit packed operation is forced |

## Verification
Three things can happen on the same rising edge that sees a word-select change. The final bit of the finishing word is captured, that word is closed and routed to its channel, and the half-period just ended is judged for packed mode. The stimulus provokes this collision with 16-clock halves, whose last bit lands exactly on the change edge, and with halves of unequal length, so that a packed decision must reach only the following word. The results are judged against a reference model in the bench. For each word, the model derives the active length from the previous completed half and the configuration, then checks both samples of every frame and the final state of `packed_o`.

// File: rtl/i2s_rx_pkg.sv
`timescale 1ns/1ps
package i2s_rx_pkg;

   // Smallest count that can hold the value n.
   function automatic int unsigned bits_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/i2s_rx_wsdet.sv
`timescale 1ns/1ps
// Word-select change detector.
// Marks the first rising edge that sees a new word-select level.
module i2s_rx_wsdet (
   input  logic clk_i,
   input  logic rst_i,
   input  logic ws_i,
   output logic ws_q_o,
   output logic bnd_o,
   output logic armed_o
);

   logic ws_q;
   logic armed;

   // Reset loads the current level, so that holding a level does not produce a false change.
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ws_q  <= ws_i;
         armed <= 1'b0;
      end else begin
         ws_q <= ws_i;
         if (bnd_o) armed <= 1'b1;
      end
   end

   assign bnd_o   = !rst_i && (ws_i != ws_q);
   assign ws_q_o  = ws_q;
   assign armed_o = armed;

endmodule

// File: rtl/i2s_rx_halfcnt.sv
`timescale 1ns/1ps
// Half-period timer, packed-frame detection and active length selection.
module i2s_rx_halfcnt #(
   parameter int SAMPLE_W  = 24,
   parameter int MIN_LEN   = 16,
   parameter int PACK_LEN  = 16,
   parameter int CNT_W     = 7,
   parameter int LEN_W     = 5,
   parameter bit AUTO_PACK = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             bnd_i,
   input  logic             armed_i,
   input  logic [LEN_W-1:0] len_cfg_i,
   output logic [LEN_W-1:0] len_act_o,
   output logic             packed_o
);

   localparam logic [LEN_W-1:0] LO_LEN = LEN_W'(MIN_LEN);
   localparam logic [LEN_W-1:0] HI_LEN = LEN_W'(SAMPLE_W);
   localparam logic [LEN_W-1:0] PK_LEN = LEN_W'(PACK_LEN);

   logic             packed_q;
   logic [LEN_W-1:0] cfg_c;

   generate
      if (AUTO_PACK) begin : g_auto
         localparam logic [CNT_W-1:0] PK_LAST = CNT_W'(PACK_LEN - 1);
         logic [CNT_W-1:0] hc;

         // hc counts the edges since the last change; it saturates, so long halves never look packed.
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               hc       <= '0;
               packed_q <= 1'b0;
            end else if (bnd_i) begin
               hc <= '0;
               if (armed_i) packed_q <= (hc == PK_LAST);
            end else if (hc != {CNT_W{1'b1}}) begin
               hc <= hc + 1'b1;
            end
         end
      end else begin : g_fixed
         assign packed_q = 1'b0;
      end
   endgenerate

   always_comb begin
      if (len_cfg_i < LO_LEN)      cfg_c = LO_LEN;
      else if (len_cfg_i > HI_LEN) cfg_c = HI_LEN;
      else                         cfg_c = len_cfg_i;
   end

   assign len_act_o = packed_q ? PK_LEN : cfg_c;
   assign packed_o  = packed_q;

endmodule

// File: rtl/i2s_rx_deser.sv
`timescale 1ns/1ps
// Deserialiser: places bits MSB first and leaves the unused low bits at zero.
module i2s_rx_deser #(
   parameter int SAMPLE_W = 24,
   parameter int LEN_W    = 5
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                bnd_i,
   input  logic                armed_i,
   input  logic                sd_i,
   input  logic [LEN_W-1:0]    len_act_i,
   output logic [SAMPLE_W-1:0] word_o,
   output logic                done_o
);

   localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(SAMPLE_W - 1);

   logic [SAMPLE_W-1:0] sh;
   logic [LEN_W-1:0]    cnt;
   logic [LEN_W-1:0]    idx;
   logic                take;

   assign take = armed_i && (cnt < len_act_i);
   assign idx  = TOP_IDX - cnt;

   always_comb begin
      word_o = sh;
      if (take) word_o[idx] = sd_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i || bnd_i) begin
         sh  <= '0;
         cnt <= '0;
      end else if (take) begin
         sh  <= word_o;
         cnt <= cnt + 1'b1;
      end
   end

   assign done_o = bnd_i && armed_i;

endmodule

// File: rtl/i2s_rx.sv
`timescale 1ns/1ps
// Top level: I2S receiver with word pairing and the valid strobe.
module i2s_rx #(
   parameter int SAMPLE_W  = 24,
   parameter int MIN_LEN   = 16,
   parameter int PACK_LEN  = 16,
   parameter int CNT_W     = 7,
   parameter bit AUTO_PACK = 1'b1,
   parameter int LEN_W     = i2s_rx_pkg::bits_for(SAMPLE_W)
) (
   input  logic                bclk_i,
   input  logic                rst_i,
   input  logic                ws_i,
   input  logic                sd_i,
   input  logic [LEN_W-1:0]    len_cfg_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o,
   output logic                packed_o
);

   generate
      if (MIN_LEN < 1 || MIN_LEN > SAMPLE_W) begin : g_bad_min
         $error("i2s_rx: MIN_LEN must lie in 1..SAMPLE_W");
      end
      if (PACK_LEN < 1 || PACK_LEN > SAMPLE_W) begin : g_bad_pack
         $error("i2s_rx: PACK_LEN must lie in 1..SAMPLE_W");
      end
      if (PACK_LEN >= (1 << CNT_W) - 1) begin : g_bad_cnt
         $error("i2s_rx: CNT_W too narrow for PACK_LEN");
      end
   endgenerate

   logic                ws_q;
   logic                bnd;
   logic                armed;
   logic [LEN_W-1:0]    len_act;
   logic [SAMPLE_W-1:0] word;
   logic                done;
   logic [SAMPLE_W-1:0] left_hold;
   logic                left_have;

   i2s_rx_wsdet u_wsdet (
      .clk_i   (bclk_i),
      .rst_i   (rst_i),
      .ws_i    (ws_i),
      .ws_q_o  (ws_q),
      .bnd_o   (bnd),
      .armed_o (armed)
   );

   i2s_rx_halfcnt #(
      .SAMPLE_W  (SAMPLE_W),
      .MIN_LEN   (MIN_LEN),
      .PACK_LEN  (PACK_LEN),
      .CNT_W     (CNT_W),
      .LEN_W     (LEN_W),
      .AUTO_PACK (AUTO_PACK)
   ) u_halfcnt (
      .clk_i     (bclk_i),
      .rst_i     (rst_i),
      .bnd_i     (bnd),
      .armed_i   (armed),
      .len_cfg_i (len_cfg_i),
      .len_act_o (len_act),
      .packed_o  (packed_o)
   );

   i2s_rx_deser #(
      .SAMPLE_W (SAMPLE_W),
      .LEN_W    (LEN_W)
   ) u_deser (
      .clk_i     (bclk_i),
      .rst_i     (rst_i),
      .bnd_i     (bnd),
      .armed_i   (armed),
      .sd_i      (sd_i),
      .len_act_i (len_act),
      .word_o    (word),
      .done_o    (done)
   );

   // ws_q is the level of the finishing word: 0 means left, 1 means right.
   always_ff @(posedge bclk_i) begin
      if (rst_i) begin
         left_hold <= '0;
         left_have <= 1'b0;
         left_o    <= '0;
         right_o   <= '0;
         valid_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (done) begin
            if (!ws_q) begin
               left_hold <= word;
               left_have <= 1'b1;
            end else begin
               if (left_have) begin
                  left_o  <= left_hold;
                  right_o <= word;
                  valid_o <= 1'b1;
               end
               left_have <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/i2s_rx_chk.sv
`timescale 1ns/1ps
// Property checker, attached to every i2s_rx instance.
module i2s_rx_chk #(
   parameter int SAMPLE_W = 24,
   parameter int MIN_LEN  = 16,
   parameter int LEN_W    = 5
) (
   input logic                bclk_i,
   input logic                rst_i,
   input logic                ws_i,
   input logic [LEN_W-1:0]    len_cfg_i,
   input logic [SAMPLE_W-1:0] left_o,
   input logic [SAMPLE_W-1:0] right_o,
   input logic                valid_o,
   input logic                packed_o
);

   logic [LEN_W-1:0] cfg_c;

   always_comb begin
      if (len_cfg_i < LEN_W'(MIN_LEN))       cfg_c = LEN_W'(MIN_LEN);
      else if (len_cfg_i > LEN_W'(SAMPLE_W)) cfg_c = LEN_W'(SAMPLE_W);
      else                                   cfg_c = len_cfg_i;
   end

   a_r8_single_pulse: assert property (@(posedge bclk_i) disable iff (rst_i)
      valid_o |=> !valid_o);

   a_r8_after_right: assert property (@(posedge bclk_i) disable iff (rst_i)
      valid_o |-> (!$past(rst_i) && !$past(ws_i) && $past(ws_i, 2)));

   a_r6_packed_at_edge: assert property (@(posedge bclk_i) disable iff (rst_i)
      (!$past(rst_i) && packed_o != $past(packed_o)) |-> ($past(ws_i) != $past(ws_i, 2)));

   a_r4_zero_fill: assert property (@(posedge bclk_i) disable iff (rst_i)
      valid_o |-> (((left_o << cfg_c) == '0) && ((right_o << cfg_c) == '0)));

   a_r9_reset_clear: assert property (@(posedge bclk_i) disable iff (rst_i)
      $past(rst_i) |-> (!valid_o && !packed_o && left_o == '0 && right_o == '0));

endmodule

bind i2s_rx i2s_rx_chk #(
   .SAMPLE_W (SAMPLE_W),
   .MIN_LEN  (MIN_LEN),
   .LEN_W    (LEN_W)
) u_chk (
   .bclk_i    (bclk_i),
   .rst_i     (rst_i),
   .ws_i      (ws_i),
   .len_cfg_i (len_cfg_i),
   .left_o    (left_o),
   .right_o   (right_o),
   .valid_o   (valid_o),
   .packed_o  (packed_o)
);

// File: tb/i2s_rx_tb.sv
`timescale 1ns/1ps
module i2s_rx_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ws  = 1'b1;
   logic        sd  = 1'b0;
   logic [4:0]  cfg = 5'd24;
   logic [23:0] left_o, right_o;
   logic        valid_o, packed_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   i2s_rx u_dut (
      .bclk_i    (clk),
      .rst_i     (rst),
      .ws_i      (ws),
      .sd_i      (sd),
      .len_cfg_i (cfg),
      .left_o    (left_o),
      .right_o   (right_o),
      .valid_o   (valid_o),
      .packed_o  (packed_o)
   );

   // Each entry holds {cfg, left1, right1, left2, right2}: the configured length, then the clock count of each half.
   localparam logic [28:0] VEC [10] = '{
      {5'd24, 6'd24, 6'd24, 6'd24, 6'd24},
      {5'd16, 6'd16, 6'd16, 6'd16, 6'd16},
      {5'd24, 6'd16, 6'd16, 6'd16, 6'd16},
      {5'd20, 6'd32, 6'd32, 6'd32, 6'd32},
      {5'd18, 6'd40, 6'd20, 6'd25, 6'd33},
      {5'd24, 6'd32, 6'd16, 6'd32, 6'd32},
      {5'd22, 6'd16, 6'd40, 6'd40, 6'd16},
      {5'd17, 6'd17, 6'd17, 6'd17, 6'd17},
      {5'd10, 6'd20, 6'd20, 6'd20, 6'd20},
      {5'd30, 6'd30, 6'd30, 6'd30, 6'd30}
   };

   logic [23:0] exp_l [8];
   logic [23:0] exp_r [8];
   int wr = 0, rd = 0, got = 0;
   logic carry = 1'b0;
   bit   prev_ok = 1'b0;
   int   prev_h = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Outputs are compared on the falling edge, away from the edges at which they change.
   always @(negedge clk) begin
      if (!rst && valid_o) begin
         got++;
         if (rd < wr) begin
            check(left_o == exp_l[rd], "R1/R2/R4", "left sample", {24'h0, left_o}, {24'h0, exp_l[rd]});
            check(right_o == exp_r[rd], "R2/R5/R7", "right sample", {24'h0, right_o}, {24'h0, exp_r[rd]});
            rd++;
         end else begin
            check(1'b0, "R8", "unexpected valid", 48'd1, 48'd0);
         end
      end
   end

   function automatic logic [23:0] pat(input int i, input int k);
      logic [23:0] x;
      x = 24'hA5C3F1 ^ 24'(i * 1267739) ^ 24'(k * 2386093);
      return {x[22:0], x[23] ^ x[3]} | 24'h000001;
   endfunction

   function automatic int cfg_clamp(input logic [4:0] c);
      return (c < 16) ? 16 : ((c > 24) ? 24 : int'(c));
   endfunction

   function automatic logic [23:0] keep_top(input logic [23:0] p, input int n);
      logic [23:0] m = '0;
      for (int i = 0; i < 24; i++) if (i < n) m[23-i] = 1'b1;
      return p & m;
   endfunction

   task automatic drive(input logic w, input logic s);
      @(negedge clk);
      ws = w;
      sd = s;
   endtask

   // Serial position q of a half; bits past the 24-bit pattern are ones, which the receiver must ignore.
   function automatic logic posbit(input logic [23:0] p, input int q);
      return (q < 24) ? p[23-q] : 1'b1;
   endfunction

   task automatic send_half(input logic w, input logic [23:0] p, input int h);
      for (int j = 0; j < h; j++) drive(w, (j == 0) ? carry : posbit(p, j - 1));
      carry = posbit(p, h - 1);
   endtask

   task automatic do_reset(input logic w, input logic [4:0] c);
      @(negedge clk);
      rst = 1'b1; ws = w; sd = 1'b0; cfg = c;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(!valid_o && !packed_o && left_o == '0 && right_o == '0, "R9", "reset state",
            {valid_o, packed_o, left_o, 22'h0}, 48'h0);
      carry = 1'b0; prev_ok = 1'b0; prev_h = 0;
      wr = 0; rd = 0; got = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int v = 0; v < 10; v++) begin
         logic [4:0] c;
         int hs [4];
         logic [23:0] el;
         c = VEC[v][28:24];
         hs[0] = int'(VEC[v][23:18]); hs[1] = int'(VEC[v][17:12]);
         hs[2] = int'(VEC[v][11:6]);  hs[3] = int'(VEC[v][5:0]);
         do_reset(1'b1, c);
         repeat (3) drive(1'b1, 1'b0);
         el = '0;
         for (int k = 0; k < 4; k++) begin
            logic [23:0] p;
            int l, n;
            p = pat(v, k);
            // R3/R6: the active length follows the previous completed half.
            l = (prev_ok && prev_h == 16) ? 16 : cfg_clamp(c);
            n = (l < hs[k]) ? l : hs[k];
            if (k % 2 == 0) el = keep_top(p, n);
            else begin
               exp_l[wr] = el; exp_r[wr] = keep_top(p, n); wr++;
            end
            send_half(logic'(k % 2), p, hs[k]);
            prev_ok = 1'b1; prev_h = hs[k];
         end
         send_half(1'b0, 24'h0, 3);
         repeat (2) drive(1'b0, 1'b0);
         check(got == 2, "R8", "valid count", 48'(got), 48'd2);
         check(packed_o == (prev_h == 16), "R6", "packed flag", {47'h0, packed_o}, {47'h0, prev_h == 16});
      end

      // R10: reset in the middle of a left word; that partial word and its lone right partner give no pair.
      do_reset(1'b0, 5'd24);
      repeat (10) drive(1'b0, 1'b1);
      send_half(1'b1, 24'h123456, 24);
      send_half(1'b0, 24'hC0FFEE, 24);
      exp_l[wr] = 24'hC0FFEE; exp_r[wr] = 24'h5A5A5B; wr++;
      send_half(1'b1, 24'h5A5A5B, 24);
      send_half(1'b0, 24'h0, 3);
      repeat (2) drive(1'b0, 1'b0);
      check(got == 1, "R10", "valid count after mid-word reset", 48'(got), 48'd1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule